// File: doc/BRIEF.md
# Nibble-wide peripheral register access fabric

This block is the slave side of a 4-bit peripheral bus on a small microcontroller. Each bus cycle is a strobe that carries a direction (IN reads, OUT writes), a 4-bit module address and a 4-bit data nibble. The fabric holds three slaves. The first is a redirect module: one write to it names another module, whose next access then goes to that module's secondary register instead of its main one. The second is a two-register module with a nibble-wide main register and a byte-wide secondary register. The third is an indexed module: a 4-bit pointer selects one of sixteen byte-wide bank entries.

Byte-wide registers move as two successive accesses, low nibble first and high nibble second. A byte register changes only when its high nibble arrives, so no half-written value is ever visible. Read data is registered. It appears on the read port in the cycle after an IN strobe and is zero in every other cycle. Each module drives zero unless it is read, and the read port is the OR of all module outputs.

Top module: `nibio_fabric`

## Requirements
- R1: While `rst_n` is low, and after reset is released, the read port is 0. The main register, the secondary byte, every bank entry and the pending redirect all read back as 0, and the indexed module waits for a pointer.
- R2: With no redirect pending, an OUT to the two-register module (address 2) writes its main nibble. An IN to that address returns the main nibble on `rdata_o` in the cycle after the strobe.
- R3: An OUT to the redirect module (address 15) records the data nibble as the target address. While that target is pending, an IN to address 15 returns it; otherwise the IN returns 0. The pending target is consumed by the first access to the two-register module, which then runs a secondary-byte transfer.
- R4: A secondary-byte write takes two OUTs to address 2, the low nibble and then the high nibble. The byte takes its new value only on the high nibble, and the main nibble does not change.
- R5: A secondary-byte read returns bits 3:0 on the first IN and bits 7:4 on the second. After the second nibble, the next access without a new redirect goes to the main nibble.
- R6: A later OUT to the redirect module that names a different address replaces the pending target. The two-register module then stays on its main nibble.
- R7: An OUT to the indexed module (address 1) while it waits for a pointer loads the pointer. The next two accesses transfer bits 3:0 and then bits 7:4 of the selected entry. A write commits on the high nibble only, and the module then waits for a pointer again.
- R8: An IN to the indexed module while it waits for a pointer returns 0 and leaves the module waiting for a pointer.
- R9: An access to any other address returns 0 on a read. A write to such an address changes no register of the fabric.
- R10: `rdata_o` is 0 in every cycle that does not follow an IN strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stb_i | input | 1 | Bus access strobe, one access per cycle |
| wr_i | input | 1 | 1 = OUT (write), 0 = IN (read) |
| addr_i | input | 4 | Module address |
| wdata_i | input | 4 | Write data nibble |
| rdata_o | output | 4 | Registered read data, valid the cycle after an IN |

## Verification
Two things happen on the same edge when the high nibble of a byte write arrives: the byte takes its new value, and the module leaves its byte transfer. For the two-register module that means returning to the main nibble; for the indexed module it means waiting for a pointer again. The bench provokes this with back-to-back strobes. A secondary high-nibble OUT is followed at once by an IN of the main nibble, and an indexed high-nibble OUT is followed at once by a new pointer OUT. Both behaviours are judged on the same run: the next access must land on the main nibble or the pointer, and a later read of the byte must return the full committed value.

// File: rtl/nibio_pkg.sv
package nibio_pkg;
  typedef enum logic [1:0] {
    IX_WAIT_PTR = 2'd0,
    IX_LO       = 2'd1,
    IX_HI       = 2'd2
  } ix_state_e;
endpackage

// File: rtl/nibio_redirect.sv
module nibio_redirect #(
  parameter int AW = 4,
  parameter logic [AW-1:0] MY_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          consume_i,
  output logic          pend_o,
  output logic [AW-1:0] tag_o,
  output logic [AW-1:0] rd_o
);
  logic          hit;
  logic          pend_q, pend_n;
  logic [AW-1:0] tag_q, tag_n;
  logic          en;

  assign hit = stb_i && (addr_i == MY_ADDR);

  always_comb begin
    pend_n = pend_q;
    tag_n  = tag_q;
    if (hit && wr_i) begin
      pend_n = 1'b1;
      tag_n  = wdata_i;
    end else if (consume_i) begin
      pend_n = 1'b0;
      tag_n  = '0;
    end
  end

  assign en = (hit && wr_i) || consume_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tag_q  <= '0;
    end else if (en) begin
      pend_q <= pend_n;
      tag_q  <= tag_n;
    end
  end

  assign pend_o = pend_q;
  assign tag_o  = tag_q;
  assign rd_o   = (hit && !wr_i && pend_q) ? tag_q : '0;

  // R3 / R6: a redirect write always leaves exactly the written target pending
  a_r6_redirect_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr_i) |=> (pend_q && tag_q == $past(wdata_i)));
endmodule

// File: rtl/nibio_dual.sv
module nibio_dual #(
  parameter int AW = 4,
  parameter int DW = 4,
  parameter logic [AW-1:0] MY_ADDR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sel_i,
  output logic          consume_o,
  output logic [DW-1:0] rd_o
);
  localparam int BW = 2 * DW;

  logic          hit, sec_now;
  logic          phase_q, phase_n;
  logic [DW-1:0] main_q, main_n;
  logic [DW-1:0] stage_q, stage_n;
  logic [BW-1:0] sec_q, sec_n;

  assign hit     = stb_i && (addr_i == MY_ADDR);
  // a transfer already under way stays on the secondary byte
  assign sec_now = phase_q || sel_i;
  assign consume_o = hit && !phase_q && sel_i;

  always_comb begin
    phase_n = phase_q;
    main_n  = main_q;
    stage_n = stage_q;
    sec_n   = sec_q;
    if (hit) begin
      if (sec_now) begin
        phase_n = !phase_q;
        if (wr_i && !phase_q) stage_n = wdata_i;
        if (wr_i && phase_q)  sec_n   = {wdata_i, stage_q};
      end else if (wr_i) begin
        main_n = wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      main_q  <= '0;
      stage_q <= '0;
      sec_q   <= '0;
    end else if (hit) begin
      phase_q <= phase_n;
      main_q  <= main_n;
      stage_q <= stage_n;
      sec_q   <= sec_n;
    end
  end

  always_comb begin
    rd_o = '0;
    if (hit && !wr_i) begin
      if (!sec_now)     rd_o = main_q;
      else if (phase_q) rd_o = sec_q[BW-1:DW];
      else              rd_o = sec_q[DW-1:0];
    end
  end

  // R4: the secondary byte only moves on a high-nibble write
  a_r4_no_half_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && wr_i && phase_q) |=> $stable(sec_q));
  // R5: the second nibble always ends the byte transfer
  a_r5_phase_return: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && phase_q) |=> !phase_q);
  // R4: the main nibble is untouched during a secondary transfer
  a_r4_main_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sec_now) |=> $stable(main_q));
endmodule

// File: rtl/nibio_indexed.sv
module nibio_indexed
  import nibio_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 4,
  parameter logic [AW-1:0] MY_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_o
);
  localparam int BW   = 2 * DW;
  localparam int NSUB = 1 << DW;

  logic          hit;
  ix_state_e     st_q, st_n;
  logic [DW-1:0] ptr_q, ptr_n;
  logic [DW-1:0] stage_q, stage_n;
  logic [BW-1:0] bank_q [NSUB];
  logic          commit;
  logic [BW-1:0] cur;

  assign hit    = stb_i && (addr_i == MY_ADDR);
  assign commit = hit && wr_i && (st_q == IX_HI);
  assign cur    = bank_q[ptr_q];

  always_comb begin
    st_n    = st_q;
    ptr_n   = ptr_q;
    stage_n = stage_q;
    if (hit) begin
      unique case (st_q)
        IX_WAIT_PTR: if (wr_i) begin
          ptr_n = wdata_i;
          st_n  = IX_LO;
        end
        IX_LO: begin
          if (wr_i) stage_n = wdata_i;
          st_n = IX_HI;
        end
        IX_HI:   st_n = IX_WAIT_PTR;
        default: st_n = IX_WAIT_PTR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IX_WAIT_PTR;
      ptr_q   <= '0;
      stage_q <= '0;
    end else if (hit) begin
      st_q    <= st_n;
      ptr_q   <= ptr_n;
      stage_q <= stage_n;
    end
  end

  for (genvar g = 0; g < NSUB; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[g] <= '0;
      else if (commit && (ptr_q == DW'(g)))
        bank_q[g] <= {wdata_i, stage_q};
    end
  end

  always_comb begin
    rd_o = '0;
    if (hit && !wr_i) begin
      unique case (st_q)
        IX_LO:   rd_o = cur[DW-1:0];
        IX_HI:   rd_o = cur[BW-1:DW];
        default: rd_o = '0;
      endcase
    end
  end

  // R7: a pointer write moves to the low-nibble step with that pointer
  a_r7_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr_i && st_q == IX_WAIT_PTR) |=> (st_q == IX_LO && ptr_q == $past(wdata_i)));
  // R8: a read while waiting for a pointer keeps waiting
  a_r8_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wr_i && st_q == IX_WAIT_PTR) |=> (st_q == IX_WAIT_PTR));
  // R7: the selected entry is unchanged unless the high nibble is written
  a_r7_entry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cur) || !$stable(ptr_q));
endmodule

// File: rtl/nibio_fabric.sv
module nibio_fabric #(
  parameter int AW = 4,
  parameter int DW = 4,
  parameter logic [AW-1:0] REDIR_ADDR = 4'hF,
  parameter logic [AW-1:0] DUAL_ADDR  = 4'h2,
  parameter logic [AW-1:0] INDEX_ADDR = 4'h1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic          pend, consume, dual_sel;
  logic [AW-1:0] tag, rd_redir;
  logic [DW-1:0] rd_dual, rd_index;
  logic [DW-1:0] rdata_q, rdata_n;
  logic          rd_any;

  nibio_redirect #(.AW(AW), .MY_ADDR(REDIR_ADDR)) u_redir (
    .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(AW'(wdata_i)), .consume_i(consume), .pend_o(pend), .tag_o(tag),
    .rd_o(rd_redir));

  assign dual_sel = pend && (tag == DUAL_ADDR);

  nibio_dual #(.AW(AW), .DW(DW), .MY_ADDR(DUAL_ADDR)) u_dual (
    .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .sel_i(dual_sel), .consume_o(consume), .rd_o(rd_dual));

  nibio_indexed #(.AW(AW), .DW(DW), .MY_ADDR(INDEX_ADDR)) u_index (
    .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rd_o(rd_index));

  assign rd_any  = stb_i && !wr_i;
  assign rdata_n = rd_any ? (DW'(rd_redir) | rd_dual | rd_index) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign rdata_o = rdata_q;

  // R10: no IN strobe, no read data in the next cycle
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_i && !wr_i) |=> (rdata_o == '0));
  // R3: a pending target is consumed by one access of the two-register module
  a_r3_consume_once: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !(stb_i && wr_i && addr_i == REDIR_ADDR)) |=> !pend);
  // R9: reads of an address that no module claims return zero
  a_r9_unclaimed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !wr_i && addr_i != REDIR_ADDR && addr_i != DUAL_ADDR &&
     addr_i != INDEX_ADDR) |=> (rdata_o == '0));
endmodule

// File: tb/nibio_fabric_bench.sv
module nibio_fabric_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       stb, wr;
  logic [3:0] addr, wd;
  logic [3:0] rdata;
  int n_chk = 0;
  int n_bad = 0;

  localparam logic [3:0] A_RED = 4'hF, A_DUAL = 4'h2, A_IDX = 4'h1, A_NONE = 4'h5;

  always #4 clk = ~clk;

  nibio_fabric u_nibio_fabric (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .wr_i(wr), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns the read port one cycle after the strobe
  task automatic acc(input logic w, input logic [3:0] a, input logic [3:0] d,
                     output logic [3:0] r);
    stb = 1'b1; wr = w; addr = a; wd = d;
    @(negedge clk);
    r = rdata;
    stb = 1'b0;
  endtask

  task automatic put(input logic [3:0] a, input logic [3:0] d);
    logic [3:0] r;
    acc(1'b1, a, d, r);
  endtask

  task automatic get(input logic [3:0] a, output logic [3:0] r);
    acc(1'b0, a, 4'h0, r);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] r, lo, hi;
    logic [7:0] b;
    rst_n = 1'b0; stb = 1'b0; wr = 1'b0; addr = '0; wd = '0;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", {4'h0, rdata}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: everything reads zero after reset
    get(A_DUAL, r); chk("R1 main", {4'h0, r}, 8'h00);
    get(A_RED, r);  chk("R1 redirect", {4'h0, r}, 8'h00);
    get(A_IDX, r);  chk("R1 indexed waiting", {4'h0, r}, 8'h00);
    put(A_RED, A_DUAL);
    get(A_DUAL, lo); get(A_DUAL, hi);
    chk("R1 secondary byte", {hi, lo}, 8'h00);
    for (int i = 0; i < 16; i++) begin
      put(A_IDX, 4'(i)); get(A_IDX, lo); get(A_IDX, hi);
      chk("R1 bank entry", {hi, lo}, 8'h00);
    end

    // R2: main nibble sweep
    for (int i = 0; i < 16; i++) begin
      put(A_DUAL, 4'(i));
      get(A_DUAL, r);
      chk("R2 main write/read", {4'h0, r}, 8'(i));
    end
    put(A_DUAL, 4'h6);

    // R3 / R4 / R5: secondary byte sweep, main nibble held at 6
    for (int i = 0; i < 16; i++) begin
      b = 8'((i * 29 + 7) ^ 8'h5A);
      put(A_RED, A_DUAL);
      get(A_RED, r); chk("R3 redirect pending", {4'h0, r}, {4'h0, A_DUAL});
      put(A_DUAL, b[3:0]);
      get(A_RED, r); chk("R3 redirect consumed", {4'h0, r}, 8'h00);
      put(A_DUAL, b[7:4]);
      // back-to-back: main nibble read right after the commit
      get(A_DUAL, r); chk("R4 main kept", {4'h0, r}, 8'h06);
      put(A_RED, A_DUAL);
      get(A_DUAL, lo); get(A_DUAL, hi);
      chk("R5 secondary read", {hi, lo}, b);
      get(A_DUAL, r); chk("R5 back to main", {4'h0, r}, 8'h06);
    end

    // R4: half-written byte not visible (low nibble only, then read via new redirect)
    put(A_RED, A_DUAL); put(A_DUAL, 4'hC);
    put(A_RED, A_DUAL);
    get(A_DUAL, r);  // finishes pending transfer as a read of bits 7:4
    chk("R4 no half write hi", {4'h0, r}, {4'h0, b[7:4]});
    get(A_DUAL, lo); get(A_DUAL, hi);
    chk("R4 byte unchanged", {hi, lo}, b);

    // R6: redirect to another module cancels the pending one
    put(A_RED, A_DUAL);
    put(A_RED, 4'h7);
    get(A_RED, r); chk("R6 new target", {4'h0, r}, 8'h07);
    put(A_DUAL, 4'h9);
    get(A_DUAL, r); chk("R6 main written", {4'h0, r}, 8'h09);
    put(A_RED, A_DUAL);
    get(A_DUAL, lo); get(A_DUAL, hi);
    chk("R6 secondary intact", {hi, lo}, b);
    put(A_RED, 4'h0);

    // R7: bank fill and readback
    for (int i = 0; i < 16; i++) begin
      b = 8'(i * 37 + 11);
      put(A_IDX, 4'(i)); put(A_IDX, b[3:0]); put(A_IDX, b[7:4]);
    end
    for (int i = 0; i < 16; i++) begin
      b = 8'(i * 37 + 11);
      put(A_IDX, 4'(i)); get(A_IDX, lo); get(A_IDX, hi);
      chk("R7 bank readback", {hi, lo}, b);
    end

    // R8: read while waiting for pointer
    get(A_IDX, r); chk("R8 wait read zero", {4'h0, r}, 8'h00);
    get(A_IDX, r); chk("R8 still waiting", {4'h0, r}, 8'h00);
    put(A_IDX, 4'h3); get(A_IDX, lo); get(A_IDX, hi);
    chk("R8 pointer taken after", {hi, lo}, 8'(3 * 37 + 11));

    // R9: unclaimed address
    for (int a = 3; a < 15; a++) begin
      put(4'(a), 4'hF);
      get(4'(a), r); chk("R9 unclaimed read", {4'h0, r}, 8'h00);
    end
    get(A_DUAL, r); chk("R9 main unchanged", {4'h0, r}, 8'h09);
    get(A_RED, r);  chk("R9 no redirect", {4'h0, r}, 8'h00);
    put(A_IDX, 4'h5); get(A_IDX, lo); get(A_IDX, hi);
    chk("R9 bank unchanged", {hi, lo}, 8'(5 * 37 + 11));

    // R10: no read data after writes or idle cycles
    stb = 1'b1; wr = 1'b1; addr = A_DUAL; wd = 4'h9;
    @(negedge clk);
    chk("R10 after write", {4'h0, rdata}, 8'h00);
    stb = 1'b0;
    @(negedge clk);
    chk("R10 idle", {4'h0, rdata}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule